// File: doc/BRIEF.md
# Background Register-Set Save Engine

When an interrupt is taken, this block copies the whole architectural register file into a context area in memory. The interrupt handler keeps running while the copy is in progress. Software supplies the base address of the context area when it starts the save. The engine then works through the registers, at best one per clock. It reads each register through a dedicated read port of the register file and issues a memory write with a valid/ready handshake.

The engine keeps two hidden flags for each register. The "saved" flag means the register's value from before the interrupt is already in memory. The "modified" flag means the handler has since overwritten that register. The engine watches the pipeline's two register-write ports on every cycle. A handler write to a register that is not yet saved is held back. That register's old value is pushed out ahead of the sweep, and then the write is released. Writes to registers that are already saved go through at once.

A terminal fault handler may cut the save short with an abort. The engine finishes any memory write already in flight and issues no further saves. It then walks the context area in index order and reloads only the registers the handler modified. Registers still unsaved are live and keep their values. When the walk ends, all flags are cleared.

Top module: `ctx_save_engine`

## Requirements
- R1: A start pulse while idle makes `busy_o` high on the next cycle, latches `base_i` and clears both flag vectors (`saved_o`, `mod_o`).
- R2: During a save, each register i is written to memory exactly once, at byte address base + i*(DW/8), with the value it held when the interrupt was taken. With memory always ready, a full save of NREG registers takes NREG+1 cycles after the start cycle.
- R3: If no handler write is in conflict, registers are saved in ascending index order. Registers that are already saved are skipped.
- R4: A memory write request keeps its address and data stable until `mem_wready_i` is high. Back-pressure only pauses the sweep, and no register is lost or repeated.
- R5: A pipeline write on either port to a register that is not yet saved is stalled until that register's old value is accepted by memory. That register is saved next, ahead of the sweep. Port 0 takes priority over port 1.
- R6: Pipeline writes to registers that are already saved, or writes made while idle, are never stalled. Every write that completes during a save sets the register's bit in `mod_o`, and a modified register is always also saved.
- R7: `done_o` pulses for exactly one cycle after the last register is accepted. At that point `saved_o` is all ones and `busy_o` is low.
- R8: A start pulse while busy is ignored: the running save keeps its base and its progress. The pulse sets `start_lost_o`, which stays high until the next accepted start.
- R9: An abort during a save lets at most the write already in flight complete, then enters restore. An abort while idle has no effect.
- R10: Restore steps i from 0 to NREG-1. For each register flagged in `mod_o` it reads address base + i*(DW/8) and writes the data back to register i. Unmodified registers are left untouched. Both pipeline write ports are stalled while restore runs.
- R11: When restore ends, `saved_o` and `mod_o` are cleared and `busy_o` drops, with no `done_o` pulse.
- R12: After reset the engine is idle: no memory request, no register write, no flags set, and `done_o` and `start_lost_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Interrupt taken: begin a save |
| base_i | input | AW | Byte base address of the context area |
| abort_i | input | 1 | Stop the save and restore the interrupted context |
| wr0_en_i | input | 1 | Pipeline write port 0 request |
| wr0_idx_i | input | IW | Pipeline write port 0 target register |
| wr1_en_i | input | 1 | Pipeline write port 1 request |
| wr1_idx_i | input | IW | Pipeline write port 1 target register |
| wr0_stall_o | output | 1 | Hold pipeline write port 0 |
| wr1_stall_o | output | 1 | Hold pipeline write port 1 |
| rf_ridx_o | output | IW | Register file read index for the save path |
| rf_rdata_i | input | DW | Register file read data (same cycle) |
| mem_wvalid_o | output | 1 | Memory write request |
| mem_waddr_o | output | AW | Memory write byte address |
| mem_wdata_o | output | DW | Memory write data |
| mem_wready_i | input | 1 | Memory accepts the write |
| mem_rvalid_o | output | 1 | Memory read request (restore) |
| mem_raddr_o | output | AW | Memory read byte address |
| mem_rready_i | input | 1 | Memory read completes this cycle |
| mem_rdata_i | input | DW | Memory read data, valid with ready |
| rf_we_o | output | 1 | Register file write from restore |
| rf_widx_o | output | IW | Restore write index |
| rf_wdata_o | output | DW | Restore write data |
| saved_o | output | NREG | Per-register saved flag |
| mod_o | output | NREG | Per-register handler-modified flag |
| busy_o | output | 1 | Save or restore in progress |
| done_o | output | 1 | One-cycle pulse: every register saved |
| start_lost_o | output | 1 | Sticky: a start arrived while busy |

## Verification
The bench builds the engine with NREG=8, DW=16 and AW=16. Because the register count is small, the bench can try every target register against every request offset from the start of the save, including offsets past the end of the sweep. This covers every relative timing of a handler write and the sweep, under both a steady memory and a memory that accepts one request in three. A model of the register file and the memory checks each address and value. The same small size lets one abort scenario be traced cycle by cycle: a stalled out-of-order save, corrupted memory entries for unmodified registers, and a write attempted during restore.

// File: rtl/ctx_save_engine.sv
module ctx_save_engine #(
  parameter int NREG = 64,
  parameter int DW   = 64,
  parameter int AW   = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [AW-1:0]            base_i,
  input  logic                     abort_i,
  input  logic                     wr0_en_i,
  input  logic [$clog2(NREG)-1:0]  wr0_idx_i,
  input  logic                     wr1_en_i,
  input  logic [$clog2(NREG)-1:0]  wr1_idx_i,
  output logic                     wr0_stall_o,
  output logic                     wr1_stall_o,
  output logic [$clog2(NREG)-1:0]  rf_ridx_o,
  input  logic [DW-1:0]            rf_rdata_i,
  output logic                     mem_wvalid_o,
  output logic [AW-1:0]            mem_waddr_o,
  output logic [DW-1:0]            mem_wdata_o,
  input  logic                     mem_wready_i,
  output logic                     mem_rvalid_o,
  output logic [AW-1:0]            mem_raddr_o,
  input  logic                     mem_rready_i,
  input  logic [DW-1:0]            mem_rdata_i,
  output logic                     rf_we_o,
  output logic [$clog2(NREG)-1:0]  rf_widx_o,
  output logic [DW-1:0]            rf_wdata_o,
  output logic [NREG-1:0]          saved_o,
  output logic [NREG-1:0]          mod_o,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     start_lost_o
);
  localparam int IW = $clog2(NREG);
  localparam int SH = $clog2(DW / 8);

  typedef enum logic [1:0] {S_IDLE, S_SAVE, S_REST} st_t;

  st_t             st;
  logic [AW-1:0]   base_q;
  logic [NREG-1:0] saved_q, mod_q, acc_mask, unsaved, oh0, oh1;
  logic [IW-1:0]   pend_idx, rptr, sweep_idx, nxt_idx;
  logic            pend_v, abort_q, done_q, lost_q;
  logic            in_idle, in_save, in_rest, acc, slot_free, abort_any;
  logic            sweep_any, u0, u1, pass0, pass1, rmod, rstep, rlast;

  assign in_idle   = st == S_IDLE;
  assign in_save   = st == S_SAVE;
  assign in_rest   = st == S_REST;
  assign acc       = pend_v && mem_wready_i;
  assign slot_free = !pend_v || acc;
  assign abort_any = abort_i || abort_q;
  assign acc_mask  = acc ? (NREG'(1) << pend_idx) : '0;
  assign unsaved   = ~saved_q & ~acc_mask;

  always_comb begin
    sweep_any = |unsaved;
    sweep_idx = '0;
    for (int i = NREG - 1; i >= 0; i--)
      if (unsaved[i]) sweep_idx = IW'(i);
  end

  assign u0      = wr0_en_i && unsaved[wr0_idx_i];
  assign u1      = wr1_en_i && unsaved[wr1_idx_i];
  assign nxt_idx = u0 ? wr0_idx_i : (u1 ? wr1_idx_i : sweep_idx);

  assign wr0_stall_o = wr0_en_i && (in_rest || (in_save && !saved_q[wr0_idx_i]));
  assign wr1_stall_o = wr1_en_i && (in_rest || (in_save && !saved_q[wr1_idx_i]));
  assign pass0 = wr0_en_i && !wr0_stall_o;
  assign pass1 = wr1_en_i && !wr1_stall_o;
  assign oh0   = (in_save && pass0) ? (NREG'(1) << wr0_idx_i) : '0;
  assign oh1   = (in_save && pass1) ? (NREG'(1) << wr1_idx_i) : '0;

  assign rf_ridx_o    = pend_idx;
  assign mem_wvalid_o = pend_v;
  assign mem_waddr_o  = base_q + (AW'(pend_idx) << SH);
  assign mem_wdata_o  = rf_rdata_i;

  assign rmod         = mod_q[rptr];
  assign rlast        = rptr == IW'(NREG - 1);
  assign rstep        = in_rest && (!rmod || mem_rready_i);
  assign mem_rvalid_o = in_rest && rmod;
  assign mem_raddr_o  = base_q + (AW'(rptr) << SH);
  assign rf_we_o      = in_rest && rmod && mem_rready_i;
  assign rf_widx_o    = rptr;
  assign rf_wdata_o   = mem_rdata_i;

  assign saved_o      = saved_q;
  assign mod_o        = mod_q;
  assign busy_o       = !in_idle;
  assign done_o       = done_q;
  assign start_lost_o = lost_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      base_q   <= '0;
      saved_q  <= '0;
      mod_q    <= '0;
      pend_v   <= 1'b0;
      pend_idx <= '0;
      rptr     <= '0;
      abort_q  <= 1'b0;
      done_q   <= 1'b0;
      lost_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !in_idle) lost_q <= 1'b1;
      case (st)
        S_IDLE: begin
          if (start_i) begin
            st      <= S_SAVE;
            base_q  <= base_i;
            saved_q <= '0;
            mod_q   <= '0;
            pend_v  <= 1'b0;
            abort_q <= 1'b0;
            lost_q  <= 1'b0;
          end
        end
        S_SAVE: begin
          if (acc) saved_q[pend_idx] <= 1'b1;
          mod_q <= mod_q | oh0 | oh1;
          if (abort_i) abort_q <= 1'b1;
          if (slot_free) begin
            if (abort_any) begin
              st      <= S_REST;
              rptr    <= '0;
              pend_v  <= 1'b0;
              abort_q <= 1'b0;
            end else if (sweep_any) begin
              pend_v   <= 1'b1;
              pend_idx <= nxt_idx;
            end else begin
              st     <= S_IDLE;
              pend_v <= 1'b0;
              done_q <= 1'b1;
            end
          end
        end
        S_REST: begin
          if (rstep) begin
            if (rlast) begin
              st      <= S_IDLE;
              saved_q <= '0;
              mod_q   <= '0;
            end else begin
              rptr <= rptr + 1'b1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ctx_save_engine_chk.sv
module ctx_save_engine_chk #(
  parameter int NREG = 64,
  parameter int DW   = 64,
  parameter int AW   = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_i,
  input logic            mem_wvalid_o,
  input logic [AW-1:0]   mem_waddr_o,
  input logic [DW-1:0]   mem_wdata_o,
  input logic            mem_wready_i,
  input logic            mem_rvalid_o,
  input logic [AW-1:0]   mem_raddr_o,
  input logic            mem_rready_i,
  input logic [NREG-1:0] saved_o,
  input logic [NREG-1:0] mod_o,
  input logic            busy_o,
  input logic            done_o,
  input logic            start_lost_o
);
  // R1
  start_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> (busy_o && saved_o == '0 && mod_o == '0));

  // R4
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wvalid_o && !mem_wready_i) |=>
      (mem_wvalid_o && $stable(mem_waddr_o) && $stable(mem_wdata_o)));

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rvalid_o && !mem_rready_i) |=> (mem_rvalid_o && $stable(mem_raddr_o)));

  // R6
  mod_saved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_o & ~saved_o) == '0);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7
  done_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (saved_o == '1 && !busy_o));

  // R8
  lost_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> start_lost_o);

  // R9
  one_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wvalid_o && mem_rvalid_o));

  // R11
  rest_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_o) && !done_o) |-> (saved_o == '0 && mod_o == '0));
endmodule

bind ctx_save_engine ctx_save_engine_chk #(.NREG(NREG), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i),
  .mem_wvalid_o(mem_wvalid_o), .mem_waddr_o(mem_waddr_o), .mem_wdata_o(mem_wdata_o),
  .mem_wready_i(mem_wready_i), .mem_rvalid_o(mem_rvalid_o), .mem_raddr_o(mem_raddr_o),
  .mem_rready_i(mem_rready_i), .saved_o(saved_o), .mod_o(mod_o), .busy_o(busy_o),
  .done_o(done_o), .start_lost_o(start_lost_o)
);

// File: tb/tb_ctx_save_engine.sv
module tb_ctx_save_engine;
  localparam int NR = 8, DW = 16, AW = 16, IW = 3, STR = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, start_i, abort_i, wr0_en_i, wr1_en_i;
  logic [AW-1:0] base_i;
  logic [IW-1:0] wr0_idx_i, wr1_idx_i, rf_ridx_o, rf_widx_o;
  logic wr0_stall_o, wr1_stall_o, mem_wvalid_o, mem_wready_i, mem_rvalid_o, mem_rready_i;
  logic [AW-1:0] mem_waddr_o, mem_raddr_o;
  logic [DW-1:0] rf_rdata_i, mem_wdata_o, mem_rdata_i, rf_wdata_o;
  logic rf_we_o, busy_o, done_o, start_lost_o;
  logic [NR-1:0] saved_o, mod_o;

  logic [DW-1:0] rf [NR];
  logic [DW-1:0] mem [NR];
  logic [DW-1:0] old [NR];
  logic [DW-1:0] wd0, wd1;
  logic [AW-1:0] cur_base;
  int wcount [NR];
  int order [64];
  int rlog [16];
  int ocnt, rcnt, cyc, mode, done_cnt, checks, errors;
  bit done_bad, st0, st1, pb0, pb1;

  ctx_save_engine #(.NREG(NR), .DW(DW), .AW(AW)) dut (.*);

  assign rf_rdata_i = rf[rf_ridx_o];
  always_comb begin
    int off;
    off = int'(mem_raddr_o) - int'(cur_base);
    mem_rdata_i = (off >= 0 && off / STR < NR) ? mem[off / STR] : '0;
  end

  always begin
    @(posedge clk); #3;
    if (done_o) begin
      done_cnt++;
      if (saved_o != '1) done_bad = 1'b1;
    end
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit rdy();
    case (mode)
      1: return (cyc % 3) == 0;
      2: return (cyc % 2) == 1;
      default: return 1'b1;
    endcase
  endfunction

  task automatic tick();
    bit p0, p1, we;
    int off, idx, widx;
    logic [DW-1:0] wdat;
    mem_wready_i = rdy();
    mem_rready_i = rdy();
    #2;
    if (mem_wvalid_o && mem_wready_i) begin
      off = int'(mem_waddr_o) - int'(cur_base);
      idx = off / STR;
      if (off < 0 || off % STR != 0 || idx >= NR)
        chk(0, "R2", "write address", mem_waddr_o, cur_base);
      else begin
        mem[idx] = mem_wdata_o;
        wcount[idx]++;
        if (ocnt < 64) order[ocnt] = idx;
        ocnt++;
      end
    end
    p0 = wr0_en_i && !wr0_stall_o;
    p1 = wr1_en_i && !wr1_stall_o;
    st0 = wr0_en_i && wr0_stall_o;
    st1 = wr1_en_i && wr1_stall_o;
    if (p0) pb0 = busy_o;
    if (p1) pb1 = busy_o;
    we = rf_we_o; widx = rf_widx_o; wdat = rf_wdata_o;
    if (we && rcnt < 16) begin rlog[rcnt] = widx; rcnt++; end
    @(posedge clk); #1;
    if (p0) begin rf[wr0_idx_i] = wd0; wr0_en_i = 1'b0; end
    if (p1) begin rf[wr1_idx_i] = wd1; wr1_en_i = 1'b0; end
    if (we) rf[widx] = wdat;
    cyc++;
    @(negedge clk);
  endtask

  task automatic init_rf(int seed);
    for (int i = 0; i < NR; i++) begin
      rf[i] = DW'(seed * 1031 + i * 257 + 3);
      old[i] = rf[i];
      mem[i] = 16'hBAD0 | DW'(i);
      wcount[i] = 0;
    end
    ocnt = 0; rcnt = 0; done_cnt = 0; done_bad = 1'b0;
  endtask

  task automatic start_save(logic [AW-1:0] b);
    cur_base = b; base_i = b; start_i = 1'b1;
    tick();
    start_i = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while ((busy_o || wr0_en_i || wr1_en_i) && n < 500) begin tick(); n++; end
    if (n >= 500) chk(0, "WD", "engine hung", n, 500);
  endtask

  task automatic chk_mem_all(string req);
    bit ok = 1'b1;
    for (int i = 0; i < NR; i++) if (mem[i] !== old[i] || wcount[i] != 1) ok = 1'b0;
    chk(ok, req, "context block contents", ocnt, NR);
  endtask

  initial begin
    int n, oreq, pos, oab, stalls;
    bit was_saved, busy_now, ok;
    checks = 0; errors = 0; cyc = 0; mode = 0;
    rst_n = 1'b0; start_i = 0; abort_i = 0; base_i = '0; cur_base = '0;
    wr0_en_i = 0; wr1_en_i = 0; wr0_idx_i = '0; wr1_idx_i = '0; wd0 = '0; wd1 = '0;
    mem_wready_i = 1'b1; mem_rready_i = 1'b1;
    init_rf(0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(!busy_o && !done_o && !mem_wvalid_o && !mem_rvalid_o && !rf_we_o, "R12",
        "idle outputs", {busy_o, done_o, mem_wvalid_o, mem_rvalid_o, rf_we_o}, 0);
    chk(saved_o == '0 && mod_o == '0 && !start_lost_o, "R12", "flags", {saved_o, mod_o}, 0);

    // R1 R2 R3 R7: plain saves under three memory patterns
    for (int m = 0; m < 3; m++) begin
      mode = m;
      init_rf(100 + m);
      start_save(16'h0200 + AW'(m * 16'h40));
      chk(busy_o && saved_o == '0 && mod_o == '0, "R1", "busy after start", busy_o, 1);
      wait_idle(n);
      chk_mem_all("R2");
      ok = 1'b1;
      for (int i = 0; i < NR; i++) if (order[i] != i) ok = 1'b0;
      chk(ok, "R3", "ascending sweep order", order[1], 1);
      chk(done_cnt == 1 && !done_bad, "R7", "single done pulse, full flags", done_cnt, 1);
      if (m == 0) chk(n == NR + 1, "R2", "cycles for full save", n, NR + 1);
    end

    // R4 R5 R6: every target register at every request offset
    for (int t = 0; t < NR; t++) begin
      for (int d = 0; d < NR + 3; d++) begin
        mode = (t + d) % 2;
        init_rf(t * 16 + d);
        start_save(16'h0100);
        repeat (d) tick();
        was_saved = wcount[t] > 0;
        busy_now = busy_o;
        oreq = ocnt;
        wr0_idx_i = IW'(t); wd0 = ~old[t]; wr0_en_i = 1'b1; stalls = 0; pb0 = 1'b0;
        while (wr0_en_i) begin tick(); if (st0) stalls++; end
        wait_idle(n);
        chk_mem_all("R4");
        chk(rf[t] === ~old[t], "R6", "handler value lands", rf[t], ~old[t]);
        chk(mod_o[t] == pb0, "R6", "modified flag", mod_o[t], pb0);
        if (busy_now && !was_saved) begin
          chk(stalls > 0, "R5", "stall on unsaved target", stalls, 1);
          pos = -1;
          for (int i = 0; i < NR; i++) if (order[i] == t) pos = i;
          chk(pos >= oreq && pos <= oreq + 1, "R5", "out-of-order save position", pos, oreq);
        end else begin
          chk(stalls == 0, "R6", "no stall on saved or idle target", stalls, 0);
        end
      end
    end

    // R5 port priority: two unsaved targets on both ports
    mode = 0;
    init_rf(77);
    start_save(16'h0300);
    tick();
    wr0_idx_i = 3'd6; wd0 = 16'h1111; wr0_en_i = 1'b1;
    wr1_idx_i = 3'd3; wd1 = 16'h2222; wr1_en_i = 1'b1;
    wait_idle(n);
    ok = order[0] == 0 && order[1] == 6 && order[2] == 3 && order[3] == 1 &&
         order[4] == 2 && order[5] == 4 && order[6] == 5 && order[7] == 7;
    chk(ok, "R5", "save order with two conflicts", order[1] * 16 + order[2], 16'h63);
    chk(rf[6] == 16'h1111 && rf[3] == 16'h2222, "R5", "both writes land", rf[6], 16'h1111);
    chk_mem_all("R5");

    // R8: start while busy
    init_rf(55);
    start_save(16'h0400);
    tick(); tick();
    base_i = 16'h0800; start_i = 1'b1;
    tick();
    start_i = 1'b0;
    chk(start_lost_o == 1'b1, "R8", "lost-start flag", start_lost_o, 1);
    wait_idle(n);
    chk_mem_all("R8");
    chk(done_cnt == 1, "R8", "save not restarted", done_cnt, 1);
    init_rf(56);
    start_save(16'h0400);
    chk(start_lost_o == 1'b0, "R8", "flag cleared by accepted start", start_lost_o, 0);
    wait_idle(n);

    // R9: abort while idle is ignored
    abort_i = 1'b1; tick(); abort_i = 1'b0; tick();
    chk(!busy_o && !mem_rvalid_o && !rf_we_o, "R9", "idle abort ignored", busy_o, 0);

    // R9 R10 R11: abort mid-save and restore
    mode = 0;
    init_rf(91);
    start_save(16'h0500);
    repeat (3) tick();
    wr0_idx_i = 3'd0; wd0 = 16'hA0A0; wr0_en_i = 1'b1;
    wr1_idx_i = 3'd7; wd1 = 16'hB7B7; wr1_en_i = 1'b1;
    while (wr0_en_i || wr1_en_i) tick();
    chk(mod_o[0] && mod_o[7], "R6", "mods recorded", mod_o, 8'h81);
    oab = ocnt;
    abort_i = 1'b1;
    tick();
    abort_i = 1'b0;
    for (int i = 1; i < 7; i++) mem[i] = 16'hBAD0 | DW'(i);
    tick();
    wr0_idx_i = 3'd2; wd0 = 16'hC2C2; wr0_en_i = 1'b1;
    tick();
    chk(st0 == 1'b1, "R10", "pipeline stalled during restore", st0, 1);
    wait_idle(n);
    chk(ocnt <= oab + 1 && ocnt < NR, "R9", "no saves after abort", ocnt, oab + 1);
    chk(rcnt == 2 && rlog[0] == 0 && rlog[1] == 7, "R10", "restore writes",
        rcnt * 256 + rlog[0] * 16 + rlog[1], 16'h207);
    ok = 1'b1;
    for (int i = 0; i < NR; i++) if (i != 2 && rf[i] !== old[i]) ok = 1'b0;
    chk(ok, "R10", "interrupted context restored", rf[1], old[1]);
    chk(rf[2] == 16'hC2C2, "R10", "held write lands after restore", rf[2], 16'hC2C2);
    chk(done_cnt == 0, "R11", "no done on restore", done_cnt, 0);
    chk(!busy_o && saved_o == '0 && mod_o == '0, "R11", "flags cleared", {saved_o, mod_o}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL WD watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule